// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked system read and write a byte-wide asynchronous static RAM with a 17-bit address space. The user side offers a valid/ready request channel that carries an address, a write byte and a direction flag. Results come back on a response channel: a one-cycle valid pulse, plus the read byte for reads. The memory side drives the address lines and the active-low chip-select, write-strobe and output-enable pins. It also drives a bidirectional 8-bit data bus and a separate tri-state enable that shows when the controller owns that bus.

Each timing phase is counted in clock cycles. These counts are computed at elaboration from the clock period and the memory's timing limits in picoseconds, rounded up, with a floor of one cycle. The phases are address setup, write-strobe low time, write hold, read access and bus turnaround. Writes are strobe-controlled: chip select stays low across the whole strobe, and the memory latches the byte when the strobe rises. A write that follows a read first spends turnaround cycles with the memory deselected and the bus released, so the two sides never drive the bus together.

Request back-pressure: `req_ready` is high only when the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the request fields and `req_valid` have no effect. The response channel has no back-pressure: `rsp_valid` is a single-cycle pulse that the consumer must take when it appears. A new request may be offered in the same cycle as that pulse.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, and whenever the controller is idle, the memory is deselected: `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high and `mem_dq_oe` is low. Reset takes effect without waiting for a clock edge, even in the middle of a transaction. After reset, `req_ready` is high.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the response pulse. `req_valid`, `req_addr` and `req_wdata` presented while busy change neither the memory contents, the address driven, nor the number of write strobes.
- R3: A write drives the address, chip select and data for the setup phase with the write strobe high. The strobe then goes low with chip select still low. Address and data stay stable across the low strobe and through one hold cycle after the strobe rises.
- R4: A read holds chip select and output enable low and the write strobe high for the read-access phase, with `mem_dq_oe` low throughout.
- R5: The read byte on `mem_dq` is registered on the edge that ends the access phase. `rsp_valid` pulses in the cycle where `rsp_rdata` first shows that byte, exactly read-access cycles after acceptance.
- R6: A write reports completion with a `rsp_valid` pulse after its hold cycle. This comes setup + strobe + hold cycles after acceptance, and the memory then holds the written byte.
- R7: A write that follows a read adds turnaround cycles before its setup phase. During those cycles chip select and output enable are high and the bus is not driven.
- R8: `mem_dq_oe` is never high while `mem_oe_n` is low.
- R9: `rsp_valid` is never high for two consecutive cycles, and `rsp_rdata` keeps the last read byte until the next read completes.
- R10: Each phase length is the largest of the rounded-up limits that apply to it, with a floor of one cycle. At a 5000 ps clock with the default limits, this gives a 2-cycle write strobe, a 2-cycle read access, and 1-cycle setup, hold and turnaround phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| mem_addr | output | 17 | Memory address lines |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq | inout | 8 | Bidirectional data bus |
| mem_dq_oe | output | 1 | High while the controller drives `mem_dq` |

## Verification
Two things can meet in one cycle: a response pulse ending one transaction, and the acceptance of the next request. The bench offers each new request at the very cycle the previous response appears, so every operation runs back to back. A read followed directly by a write therefore exercises completion, acceptance and the turnaround phase together. This is judged by the exact latency of each operation, by the bus-ownership state in the first cycle after acceptance, and by a bus monitor that counts any cycle where both the modelled memory and the controller drive `mem_dq`.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_RACC
  } sram_st_e;

  // Round a picosecond limit up to whole clock cycles, never below one.
  function automatic int phase_cycles(input int limit_ps, input int clk_ps);
    int n;
    n = (limit_ps <= 0) ? 1 : (limit_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_dq_pad.sv
`timescale 1ns/1ps
module sram_dq_pad #(
  parameter int DATA_W = 8
) (
  input  logic              drive,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  inout  wire  [DATA_W-1:0] dq
);
  assign dq    = drive ? wdata : {DATA_W{1'bz}};
  assign rdata = dq;
endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W  = 2,
  parameter int AS_CYC = 1,
  parameter int WP_CYC = 2,
  parameter int AH_CYC = 1,
  parameter int RD_CYC = 2,
  parameter int TA_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  output logic             req_ready,
  input  logic             tmr_last,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             rsp_valid,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);
  sram_st_e st_q, st_d;
  logic     last_rd_q;
  logic     done;

  assign req_ready = (st_q == ST_IDLE);

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    done     = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        if (!req_write) begin
          st_d    = ST_RACC;
          tmr_val = CNT_W'(RD_CYC - 1);
        end else if (last_rd_q) begin
          st_d    = ST_TURN;
          tmr_val = CNT_W'(TA_CYC - 1);
        end else begin
          st_d    = ST_WSET;
          tmr_val = CNT_W'(AS_CYC - 1);
        end
      end
      ST_TURN: if (tmr_last) begin
        st_d = ST_WSET; tmr_load = 1'b1; tmr_val = CNT_W'(AS_CYC - 1);
      end
      ST_WSET: if (tmr_last) begin
        st_d = ST_WPUL; tmr_load = 1'b1; tmr_val = CNT_W'(WP_CYC - 1);
      end
      ST_WPUL: if (tmr_last) begin
        st_d = ST_WHLD; tmr_load = 1'b1; tmr_val = CNT_W'(AH_CYC - 1);
      end
      ST_WHLD: if (tmr_last) begin
        st_d = ST_IDLE; done = 1'b1;
      end
      ST_RACC: if (tmr_last) begin
        st_d = ST_IDLE; done = 1'b1; capture = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Strobes are registered from the next state so pins never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      last_rd_q <= 1'b0;
      rsp_valid <= 1'b0;
      ce_n      <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dq_oe     <= 1'b0;
    end else begin
      st_q      <= st_d;
      rsp_valid <= done;
      ce_n      <= !(st_d inside {ST_WSET, ST_WPUL, ST_WHLD, ST_RACC});
      we_n      <= (st_d != ST_WPUL);
      oe_n      <= (st_d != ST_RACC);
      dq_oe     <= (st_d inside {ST_WSET, ST_WPUL, ST_WHLD});
      if (capture)             last_rd_q <= 1'b1;
      else if (st_d == ST_WSET) last_rd_q <= 1'b0;
    end
  end

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);
  // R3
  strobe_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && dq_oe));
  // R4
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !ce_n && !dq_oe));
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R7
  drive_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(oe_n));
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_PS    = 5000,
  parameter int T_AS_PS   = 0,
  parameter int T_AH_PS   = 0,
  parameter int T_WP_PS   = 7000,
  parameter int T_DW_PS   = 5000,
  parameter int T_AW_PS   = 8000,
  parameter int T_WC_PS   = 10000,
  parameter int T_AA_PS   = 10000,
  parameter int T_OE_PS   = 5000,
  parameter int T_RC_PS   = 10000,
  parameter int T_OHZ_PS  = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              mem_dq_oe
);
  localparam int AS_CYC  = phase_cycles(T_AS_PS, CLK_PS);
  localparam int AH_CYC  = phase_cycles(T_AH_PS, CLK_PS);
  localparam int WC_CYC  = phase_cycles(T_WC_PS, CLK_PS);
  localparam int WC_REST = (WC_CYC > AS_CYC + AH_CYC) ? WC_CYC - AS_CYC - AH_CYC : 1;
  localparam int WP_CYC  = max2(max2(phase_cycles(T_WP_PS, CLK_PS),
                                     phase_cycles(T_DW_PS, CLK_PS)),
                                max2(phase_cycles(T_AW_PS, CLK_PS), WC_REST));
  localparam int RD_CYC  = max2(max2(phase_cycles(T_AA_PS, CLK_PS),
                                     phase_cycles(T_OE_PS, CLK_PS)),
                                phase_cycles(T_RC_PS, CLK_PS));
  localparam int TA_CYC  = phase_cycles(T_OHZ_PS, CLK_PS);
  localparam int MAX_CYC = max2(max2(max2(AS_CYC, AH_CYC), max2(WP_CYC, RD_CYC)), TA_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic              tmr_load, tmr_last, accept, capture;
  logic [CNT_W-1:0]  tmr_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, dq_in;

  sram_ctrl_fsm #(
    .CNT_W(CNT_W), .AS_CYC(AS_CYC), .WP_CYC(WP_CYC),
    .AH_CYC(AH_CYC), .RD_CYC(RD_CYC), .TA_CYC(TA_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
    .tmr_last(tmr_last), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .accept(accept), .capture(capture), .rsp_valid(rsp_valid),
    .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(mem_dq_oe)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  sram_dq_pad #(.DATA_W(DATA_W)) u_pad (
    .drive(mem_dq_oe), .wdata(wdata_q), .rdata(dq_in), .dq(mem_dq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= dq_in;
    end
  end

  assign mem_addr  = addr_q;
  assign rsp_rdata = rdata_q;

  // R2
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(mem_addr));
  // R3
  strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(mem_dq_oe)));
  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !rsp_valid) |=> $stable(rsp_rdata) || rsp_valid);
endmodule

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  wire  [7:0]  mem_dq;

  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sram_async_ctrl u_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq(mem_dq), .mem_dq_oe(mem_dq_oe)
  );

  // Expected phase lengths from the timing limits at a 5000 ps clock (R10).
  function automatic int bcyc(input int ps);
    int n;
    n = (ps <= 0) ? 1 : (ps + 4999) / 5000;
    return (n < 1) ? 1 : n;
  endfunction
  function automatic int bmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int AS_E = bcyc(0);
  localparam int AH_E = bcyc(0);
  localparam int WP_E = bmax(bmax(bcyc(7000), bcyc(5000)),
                             bmax(bcyc(8000), bmax(bcyc(10000) - AS_E - AH_E, 1)));
  localparam int RD_E = bmax(bmax(bcyc(10000), bcyc(5000)), bcyc(10000));
  localparam int TA_E = bcyc(4000);
  localparam int WR_E = AS_E + WP_E + AH_E;

  // Memory model.
  logic [7:0] store [int];
  logic [7:0] shadow [int];
  int         wr_events = 0;
  logic       mdrv;
  logic [7:0] mdata;

  always @(posedge mem_we_n)
    if (rst_n && mem_ce_n === 1'b0) begin
      store[int'(mem_addr)] = mem_dq;
      wr_events++;
    end

  always @* mdrv = (mem_ce_n === 1'b0) && (mem_oe_n === 1'b0) && (mem_we_n === 1'b1);
  always @(mem_addr, mem_ce_n, mem_oe_n, wr_events)
    mdata = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : 8'h00;
  assign mem_dq = mdrv ? mdata : 8'hzz;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bus and strobe monitors.
  int contention = 0, we_run = 0, addr_moves = 0, ce_bad = 0;
  logic [16:0] we_addr;
  always @(negedge clk) if (rst_n) begin
    if (mdrv && mem_dq_oe) contention++;
    if (!mem_we_n) begin
      if (we_run > 0 && mem_addr != we_addr) addr_moves++;
      if (mem_ce_n) ce_bad++;
      we_addr = mem_addr;
      we_run++;
    end else if (we_run > 0) begin
      chk(we_run == WP_E, "R10", "write strobe low cycles", we_run, WP_E);
      we_run = 0;
    end
  end

  bit prev_read = 1'b0;

  task automatic run_op(input bit wr, input logic [16:0] a, input logic [7:0] d,
                        input bit noise);
    int lat, cnt, wbefore;
    logic [7:0] exp;
    while (!req_ready) @(negedge clk);
    lat     = wr ? (WR_E + (prev_read ? TA_E : 0)) : RD_E;
    wbefore = wr_events;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    cnt = 0;
    chk(!req_ready, "R2", "ready low after accept", req_ready, 0);
    if (!wr)
      chk(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe, "R4", "read strobes",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
    else if (prev_read)
      chk(mem_ce_n && mem_oe_n && !mem_dq_oe, "R7", "turnaround released bus",
          {mem_ce_n, mem_oe_n, mem_dq_oe}, 3'b110);
    else
      chk(!mem_ce_n && mem_we_n && mem_dq_oe, "R3", "write setup phase",
          {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b011);
    while (!rsp_valid && cnt < 50) begin
      if (noise) begin
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = 17'($urandom); req_wdata = 8'($urandom);
      end else begin
        req_valid = 1'b0; req_addr = 17'($urandom); req_wdata = 8'($urandom);
      end
      @(negedge clk);
      cnt++;
    end
    req_valid = 1'b0;
    if (wr) begin
      shadow[int'(a)] = d;
      chk(cnt == lat, "R6", "write latency", cnt, lat);
      chk(wr_events == wbefore + 1, "R2", "strobes per write", wr_events - wbefore, 1);
      chk(store.exists(int'(a)) && store[int'(a)] == d, "R6", "stored byte",
          store.exists(int'(a)) ? int'(store[int'(a)]) : -1, d);
    end else begin
      exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
      chk(cnt == lat, "R5", "read latency", cnt, lat);
      chk(rsp_rdata == exp, "R5", "read byte", rsp_rdata, exp);
      chk(wr_events == wbefore, "R2", "strobes during read", wr_events - wbefore, 0);
    end
    prev_read = !wr;
  endtask

  logic [16:0] pool [16];

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 16; i++) pool[i] = 17'($urandom);
    pool[0] = 17'h00000; pool[1] = 17'h1FFFF;

    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid, "R1",
        "standby in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1", "ready after reset", req_ready, 1);

    // Directed: write, read back, write after read, read-read-write.
    run_op(1'b1, pool[0], 8'hA5, 1'b0);
    run_op(1'b0, pool[0], 8'h00, 1'b0);
    run_op(1'b1, pool[1], 8'h3C, 1'b1);
    run_op(1'b0, pool[1], 8'h00, 1'b0);
    run_op(1'b0, pool[0], 8'h00, 1'b0);
    held = rsp_rdata;
    @(negedge clk);
    chk(!rsp_valid, "R9", "single-cycle response", rsp_valid, 0);
    chk(rsp_rdata == held, "R9", "read byte held", rsp_rdata, held);
    chk(mem_ce_n && mem_oe_n && !mem_dq_oe, "R1", "idle standby",
        {mem_ce_n, mem_oe_n, mem_dq_oe}, 3'b110);
    run_op(1'b1, pool[0], 8'h5A, 1'b0);
    run_op(1'b0, pool[0], 8'h00, 1'b0);

    // Reset in the middle of a read.
    req_valid = 1'b1; req_write = 1'b0; req_addr = pool[1];
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #0.5;
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "reset mid-read",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    @(negedge clk);
    rst_n = 1'b1;
    prev_read = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 400; i++)
      run_op(bit'($urandom % 2), pool[$urandom % 16], 8'($urandom), ($urandom % 4) == 0);
    for (int i = 0; i < 16; i++)
      run_op(1'b0, pool[i], 8'h00, 1'b0);

    repeat (2) @(negedge clk);
    chk(contention == 0, "R8", "bus contention cycles", contention, 0);
    chk(addr_moves == 0 && ce_bad == 0, "R3", "address or select moved under strobe",
        addr_moves + ce_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule